// File: doc/BRIEF.md
# Feedback Delay Line Echo

This block adds echo to a stream of signed 24-bit audio samples. It keeps a circular sample store. Each sample that arrives with its valid strobe triggers one operation on that store:

- It fetches the stored sample at the current read address.
- It blends the fetched sample with the incoming sample, using an unsigned 8-bit fraction set by the user.
- It writes the blend back at the write address.
- It presents the same blend on the output one cycle later.

Each stored blend comes back after a full trip around the store. The delayed sound therefore repeats and decays, which is a crude echo or reverb. For 50 to 100 ms of delay, size the depth from the sample rate, for example about 4800 entries for 100 ms at 48 kHz.

A second mode gives the read address its own pointer. That pointer moves by one or two entries per sample, while the write pointer always moves by one, so the delayed material is replayed at a shifted pitch. The clicks heard when the two pointers pass each other are accepted. When the block returns to the normal mode, the read address snaps back onto the write address.

Top module: `echo_line`

## Requirements
- R1: While reset is held at a clock edge, the output valid flag and the output sample are both zero.
- R2: The output valid flag is high in exactly the cycle that follows each cycle with input valid high, and low after every cycle with input valid low.
- R3: The output sample is (x*c + s*(256-c)) / 256, truncated toward zero. Here x is the input sample, s is the fetched sample and c is the unsigned 8-bit coefficient.
- R4: Reset clears every entry of the store to zero, so every fetch in the first trip around the store after reset returns zero.
- R5: In normal mode (pitch enable = 0), reading and writing use the same address. The fetched sample is the blend written DEPTH accepted samples earlier.
- R6: Addresses wrap from DEPTH-1 to 0, including when DEPTH is not a power of two (default 48).
- R7: With pitch enable = 1, the read address advances by 1 when the step select is 0 and by 2 when it is 1, wrapping modulo DEPTH. The write address advances by 1.
- R8: A cycle with input valid low changes neither the store nor either address.
- R9: Full-scale inputs (-8388608 and 8388607) with any coefficient give a result inside the 24-bit signed range, with no wrap-around.
- R10: After any sample accepted in normal mode, the read pointer equals the write pointer. This holds even after a stretch in pitch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the store and the pointers |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 24 | Signed input sample |
| mix_coef | input | 8 | Unsigned Q0.8 weight of the input sample |
| pitch_en | input | 1 | 1 selects the independent read pointer |
| pitch_step | input | 1 | Read step in pitch mode: 0 gives 1, 1 gives 2 |
| out_valid | output | 1 | Output sample strobe, one cycle after in_valid |
| out_sample | output | 24 | Signed blended sample |

## Verification
The bench drives long runs through the non-power-of-two store while it sweeps the coefficient across 0, 1, 128, 255 and other values. It compares every output against a reference model of the store and its pointers.

The corner cases each catch a specific fault:
- **Wrap point.** An off-by-one wrap would return a blend from the wrong age.
- **Negative sums.** Rounding toward minus infinity would be off by one on negative blends.
- **Full-scale extremes.** Narrow arithmetic would flip the sign of the result.
- **Idle gaps.** A design that advances on idle cycles would drift out of step with the model.
- **Pitch mode, both steps.** A wrong step or a wrong realignment would misplace every later fetch.
- **Reset in mid-stream.** A store that is not cleared would leak old echo into the first trip.

// File: rtl/echo_pkg.sv
// Package: echo_pkg
// Shared types for the feedback delay line echo.
// Assumes nothing beyond a 1-bit encoding of the read step.
package echo_pkg;

    typedef enum logic {
        STEP_SINGLE = 1'b0,
        STEP_DOUBLE = 1'b1
    } step_e;

endpackage

// File: rtl/echo_mix.sv
// Module: echo_mix
// Combinational blend of a fresh sample and a stored sample:
// (fresh*coef + stored*(FULL-coef)) / FULL with truncation toward zero.
// Assumes coef is unsigned and below FULL = 2**COEF_W, so the result is a
// convex mix and always fits in SAMPLE_W signed bits.
module echo_mix #(
    parameter int SAMPLE_W = 24,
    parameter int COEF_W   = 8
) (
    input  logic signed [SAMPLE_W-1:0] fresh,
    input  logic signed [SAMPLE_W-1:0] stored,
    input  logic        [COEF_W-1:0]   coef,
    output logic signed [SAMPLE_W-1:0] mixed
);
    localparam int ACC_W = SAMPLE_W + COEF_W + 2;
    localparam logic [ACC_W-1:0] FULL_X    = ACC_W'(1) << COEF_W;
    localparam logic [ACC_W-1:0] ROUND_ADD = FULL_X - ACC_W'(1);

    logic signed [ACC_W-1:0] fresh_x, stored_x, coef_x, comp_x;
    logic signed [ACC_W-1:0] acc, biased;

    // Sign-extend operands and form the two weights.
    always_comb begin
        fresh_x  = {{(ACC_W-SAMPLE_W){fresh[SAMPLE_W-1]}}, fresh};
        stored_x = {{(ACC_W-SAMPLE_W){stored[SAMPLE_W-1]}}, stored};
        coef_x   = {{(ACC_W-COEF_W){1'b0}}, coef};
        comp_x   = $signed(FULL_X) - coef_x;
    end

    // Weighted sum, then bias negatives so the shift truncates toward zero.
    always_comb begin
        acc    = fresh_x * coef_x + stored_x * comp_x;
        biased = acc[ACC_W-1] ? acc + $signed(ROUND_ADD) : acc;
        mixed  = SAMPLE_W'(biased >>> COEF_W);
    end

    // The blend must lie between its two operands (convex mix, no wrap).
    always_comb begin
        if (fresh <= stored) begin
            a_r9_mix_bounded_lo: assert (mixed >= fresh && mixed <= stored);
        end else begin
            a_r9_mix_bounded_hi: assert (mixed >= stored && mixed <= fresh);
        end
    end

endmodule

// File: rtl/echo_ptrs.sv
// Module: echo_ptrs
// Read and write address generation for the circular store.
// Normal mode: reads use the write address and the read pointer follows it.
// Pitch mode: the read pointer steps by 1 or 2 while the write pointer steps by 1.
// Assumes DEPTH >= 2 and PTR_W = clog2(DEPTH).
module echo_ptrs
    import echo_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             pitch_en,
    input  step_e            step_sel,
    output logic [PTR_W-1:0] rd_addr,
    output logic [PTR_W-1:0] wr_addr
);
    logic [PTR_W-1:0] rd_q, wr_q;

    // Modular increment by 1 or 2 for any depth.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                              input logic [1:0]       inc);
        logic [PTR_W:0] s;
        s = {1'b0, p} + (PTR_W+1)'(inc);
        if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    // Pointer state: advance only on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else if (advance) begin
            wr_q <= bump(wr_q, 2'd1);
            if (pitch_en)
                rd_q <= bump(rd_q, (step_sel == STEP_DOUBLE) ? 2'd2 : 2'd1);
            else
                rd_q <= bump(wr_q, 2'd1);
        end
    end

    // Select the effective read address for the current sample.
    always_comb begin
        rd_addr = pitch_en ? rd_q : wr_q;
        wr_addr = wr_q;
    end

    a_r6_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q < PTR_W'(DEPTH));
    a_r6_rd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q < PTR_W'(DEPTH));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(wr_q) && $stable(rd_q));
    a_r10_realign: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !pitch_en |=> rd_q == wr_q);
    a_r5_wr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> wr_q != $past(wr_q));

endmodule

// File: rtl/echo_store.sv
// Module: echo_store
// Circular sample store with one asynchronous read port and one synchronous
// write port. Reset clears every entry to zero.
// Assumes addresses are below DEPTH.
module echo_store #(
    parameter int DEPTH    = 48,
    parameter int SAMPLE_W = 24,
    parameter int PTR_W    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [PTR_W-1:0]    waddr,
    input  logic [SAMPLE_W-1:0] wdata,
    input  logic [PTR_W-1:0]    raddr,
    output logic [SAMPLE_W-1:0] rdata
);
    logic [SAMPLE_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise write the blend on an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Fetch the stored sample for the current operation.
    assign rdata = mem[raddr];

    a_r6_waddr_ok: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr < PTR_W'(DEPTH));
    a_r6_raddr_ok: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> raddr < PTR_W'(DEPTH));

endmodule

// File: rtl/echo_line.sv
// Module: echo_line
// Feedback delay line echo. Each valid input sample fetches a stored sample,
// blends it with the input by mix_coef, writes the blend back and outputs it
// one cycle later.
// Assumes inputs are synchronous to clk; the output is registered.
module echo_line
    import echo_pkg::*;
#(
    parameter int DEPTH    = 48,
    parameter int SAMPLE_W = 24,
    parameter int COEF_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [COEF_W-1:0]   mix_coef,
    input  logic                pitch_en,
    input  logic                pitch_step,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]    rd_addr, wr_addr;
    logic [SAMPLE_W-1:0] old_sample;
    logic signed [SAMPLE_W-1:0] blend;
    logic                valid_q;
    logic [SAMPLE_W-1:0] sample_q;

    echo_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (in_valid),
        .pitch_en (pitch_en),
        .step_sel (step_e'(pitch_step)),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr)
    );

    echo_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_valid),
        .waddr (wr_addr),
        .wdata (blend),
        .raddr (rd_addr),
        .rdata (old_sample)
    );

    echo_mix #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) u_mix (
        .fresh  ($signed(in_sample)),
        .stored ($signed(old_sample)),
        .coef   (mix_coef),
        .mixed  (blend)
    );

    // Output register: one cycle of latency from input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            sample_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) sample_q <= blend;
        end
    end

    assign out_valid  = valid_q;
    assign out_sample = sample_q;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && in_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !in_valid |=> !out_valid);
    a_r8_idle_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !in_valid |=> $stable(out_sample));

endmodule

// File: tb/tb_echo_line.sv
`timescale 1ns/1ps
module tb_echo_line;
    localparam int D = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_sample = '0;
    logic [7:0]  mix_coef = '0;
    logic        pitch_en = 1'b0;
    logic        pitch_step = 1'b0;
    logic        out_valid;
    logic [23:0] out_sample;

    int checks = 0;
    int errors = 0;
    int mem_m [D];
    int wr_m = 0;
    int rd_m = 0;
    logic [31:0] lcg = 32'h1234_5678;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    echo_line #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .mix_coef(mix_coef), .pitch_en(pitch_en), .pitch_step(pitch_step),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic int blend_ref(int x, int y, int a);
        longint s;
        s = longint'(x) * a + longint'(y) * (256 - a);
        return int'(s / 256);
    endfunction

    function automatic int next_rand();
        int v;
        lcg = lcg * 32'd1103515245 + 32'd12345;
        v = $signed(lcg[31:8]);
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < D; i++) mem_m[i] = 0;
        wr_m = 0;
        rd_m = 0;
    endtask

    task automatic send(input int x, input int a, input bit pm, input bit st,
                        input string tag);
        int old_v, exp_v;
        old_v = pm ? mem_m[rd_m] : mem_m[wr_m];
        exp_v = blend_ref(x, old_v, a);
        mem_m[wr_m] = exp_v;
        if (pm) rd_m = (rd_m + (st ? 2 : 1)) % D;
        else    rd_m = (wr_m + 1) % D;
        wr_m = (wr_m + 1) % D;
        @(negedge clk);
        in_valid = 1'b1; in_sample = x[23:0]; mix_coef = a[7:0];
        pitch_en = pm;   pitch_step = st;
        @(posedge clk); #1;
        chk(out_valid === 1'b1, {"R2 valid ", tag}, int'(out_valid), 1);
        chk(int'($signed(out_sample)) == exp_v, tag, int'($signed(out_sample)), exp_v);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sample = 24'h5A5A5A;
            @(posedge clk); #1;
            chk(out_valid === 1'b0, "R8 idle no output", int'(out_valid), 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk(out_valid === 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(out_sample === 24'd0, "R1 reset sample", int'(out_sample), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int coefs [8] = '{0, 1, 128, 255, 64, 200, 17, 254};
        model_clear();
        repeat (2) @(posedge clk);
        do_reset();

        // R4: first trip around the store sees zeros; R3 with c=128
        for (int i = 0; i < D; i++) send(next_rand(), 128, 0, 0, "R4 first pass");

        // R3/R5/R6: sweep coefficients over several trips across the wrap point
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < D + 5; i++)
                send(next_rand(), coefs[k], 0, 0, "R5 delay/R6 wrap");

        // R3: negative sums exercise truncation toward zero
        for (int i = 0; i < D; i++) send(-(i * 37 + 3), 77, 0, 0, "R3 negative trunc");

        // R9: full-scale extremes
        for (int i = 0; i < D; i++)
            send((i % 2) ? 8388607 : -8388608, (i * 53) % 256, 0, 0, "R9 extremes");
        for (int i = 0; i < D; i++) send(-8388608, 255, 0, 0, "R9 min hold");
        for (int i = 0; i < 10; i++) send(8388607, 1, 0, 0, "R9 max");

        // R8: idle gaps interleaved with samples
        for (int i = 0; i < 20; i++) begin
            idle(i % 3 + 1);
            send(next_rand(), 100, 0, 0, "R8 after idle");
        end

        // R7: pitch mode, step one then step two
        for (int i = 0; i < D + 7; i++) send(next_rand(), 90, 1, 0, "R7 step one");
        for (int i = 0; i < 2 * D + 3; i++) send(next_rand(), 150, 1, 1, "R7 step two");
        idle(2);
        for (int i = 0; i < 9; i++) send(next_rand(), 30, 1, 1, "R7 step two after idle");

        // R10: return to normal mode realigns reads with writes
        for (int i = 0; i < 2 * D; i++) send(next_rand(), 60, 0, 0, "R10 realign");

        // R1/R4: reset mid-stream, then coefficient 0 exposes stored zeros
        idle(1);
        do_reset();
        for (int i = 0; i < D; i++) send(next_rand(), 0, 0, 0, "R4 cleared store");
        for (int i = 0; i < D; i++) send(next_rand(), 180, 1, 1, "R7 after reset");

        idle(3);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule